// File: doc/BRIEF.md
# Channel and Special Register Address Decoder

This block sits between the address register of a small word-serial processor and its register file and I/O channels. It takes the 12-bit address and four generic one-step pulses: special-register read and write, and channel read and write. From these it produces per-register read and write strobes, the special-address qualifier, and the two 3-bit one-hot decodes of the address. The strobes are combinational and belong to the same step as the pulse that caused them.

Special-register accesses check all twelve address bits. Channel accesses look only at the low six bits, so every channel appears again for any value of the upper bits. Channel addresses 1 and 2 have no storage of their own. An access to one of them turns into an ordinary read or write strobe for the L or Q register. The block holds three pieces of state. The first is a 3-bit erasable bank register, which is loaded from one of two fields of the write lines depending on the target address. The second is three superbank flip-flops reachable only as channel 7. The third is one 15-bit test channel at channel address 11 (octal 13). On a channel read the block gates the channel-OR bus onto its write-line output.

Top module: `chan_addr_decoder`

## Requirements
- R1: `sc_qual` is 1 exactly when address bits 11..3 (0-based) are all zero.
- R2: `lo_dec` is the one-hot decode of address bits 2..0 and `mid_dec` the one-hot decode of address bits 5..3, driven at all times.
- R3: Register indices are 0 A, 1 L, 2 Q, 3 erasable bank, 4 fixed bank, 5 Z, 6 both-banks, 7 zero. When `sc_rd` or `sc_wr` is high and `sc_qual` is 1, the matching bit `reg_rd[addr[2:0]]` or `reg_wr[addr[2:0]]` is set. When `sc_qual` is 0, no strobe is set.
- R4: When `ch_rd` or `ch_wr` is high and address bits 5..0 equal 2, strobe bit 2 (Q) is set. When they equal 1, strobe bit 1 (L) is set. Address bits 11..6, including bit 9, do not change the result. No other channel address produces a register strobe.
- R5: A special write to address 3 loads `ebank` from write-line bits 10..8 at the next clock edge. A special write to address 6 loads it from bits 2..0. No other access changes it.
- R6: A channel write with address bits 5..0 equal to 7 loads `sbank` from write-line bits 6..4. A channel read of channel 7 returns `sbank` on `wl_out[6:4]`, with every other bit zero.
- R7: A channel write to channel 11 stores write-line bits 13..0 and bit 15. A later read of that channel returns them in the same positions, with `wl_out[14]` zero.
- R8: `wl_out` is zero when `ch_rd` is low, on a read of channel 1 or 2, and on a read of any channel without storage.
- R9: Every strobe and `wl_out` are valid in the same cycle as the pulse that produced them, with no register stage.
- R10: After reset, `ebank`, `sbank` and the test channel all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_addr | input | 12 | Address register contents |
| sc_rd | input | 1 | Generic special/central register read pulse |
| sc_wr | input | 1 | Generic special/central register write pulse |
| ch_rd | input | 1 | Generic channel read pulse |
| ch_wr | input | 1 | Generic channel write pulse |
| wl_in | input | 16 | Write lines, source of written data |
| sc_qual | output | 1 | Special-address qualifier |
| lo_dec | output | 8 | One-hot decode of address bits 2..0 |
| mid_dec | output | 8 | One-hot decode of address bits 5..3 |
| reg_rd | output | 8 | Per-register read strobes |
| reg_wr | output | 8 | Per-register write strobes |
| wl_out | output | 16 | Channel-OR bus gated onto the write lines |
| ebank | output | 3 | Erasable bank register |
| sbank | output | 3 | Superbank flip-flops (channel 7) |

## Verification
The assertions assume that at most one of the four generic pulses is high in any cycle. That assumption is what makes the strobe vectors at most one-hot and lets a load of the bank register be checked against a single source field. The stimulus keeps within it by choosing one pulse kind, or none, for each step, including in the randomised phase. Directed steps repeat the Q, L and channel 7 accesses with different upper address bits, bit 9 among them, so that aliasing is exercised at the ports.

// File: rtl/chdec_pkg.sv
package chdec_pkg;

    // Register index order is behaviour: it is the low-three-bit address
    // of each special/central register.
    typedef enum logic [2:0] {
        REG_ACC   = 3'd0,
        REG_LOWP  = 3'd1,
        REG_RET   = 3'd2,
        REG_EBK   = 3'd3,
        REG_FBK   = 3'd4,
        REG_PC    = 3'd5,
        REG_BOTH  = 3'd6,
        REG_NULL  = 3'd7
    } reg_idx_e;

    localparam int unsigned NUM_REGS = 8;

endpackage

// File: rtl/chdec_addr.sv
module chdec_addr
    import chdec_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SEL_W  = 3
) (
    input  logic [ADDR_W-1:0]     s_addr,
    input  logic                  sc_rd,
    input  logic                  sc_wr,
    input  logic                  ch_rd,
    input  logic                  ch_wr,
    output logic                  sc_qual,
    output logic [(1<<SEL_W)-1:0] lo_dec,
    output logic [(1<<SEL_W)-1:0] mid_dec,
    output logic [(1<<SEL_W)-1:0] reg_rd,
    output logic [(1<<SEL_W)-1:0] reg_wr
);
    localparam int unsigned NSEL = 1 << SEL_W;

    logic [SEL_W-1:0] lo_f;
    logic [SEL_W-1:0] mid_f;

    assign lo_f    = s_addr[SEL_W-1:0];
    assign mid_f   = s_addr[2*SEL_W-1:SEL_W];
    assign sc_qual = ~|s_addr[ADDR_W-1:SEL_W];

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign lo_dec[i]  = (lo_f == SEL_W'(i));
        assign mid_dec[i] = (mid_f == SEL_W'(i));

        if (i == int'(REG_LOWP) || i == int'(REG_RET)) begin : g_chmap
            // channel alias: only the low six bits take part
            assign reg_rd[i] = (sc_rd & sc_qual & lo_dec[i]) |
                               (ch_rd & mid_dec[0] & lo_dec[i]);
            assign reg_wr[i] = (sc_wr & sc_qual & lo_dec[i]) |
                               (ch_wr & mid_dec[0] & lo_dec[i]);
        end else begin : g_sconly
            assign reg_rd[i] = sc_rd & sc_qual & lo_dec[i];
            assign reg_wr[i] = sc_wr & sc_qual & lo_dec[i];
        end
    end

endmodule

// File: rtl/chdec_ebank.sv
module chdec_ebank #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned EB_W      = 3,
    parameter int unsigned EB_HI_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [WORD_W-1:0] wl,
    output logic [EB_W-1:0]   ebank
);
    typedef struct packed {
        logic [EB_W-1:0] eb;
    } eb_state_t;

    eb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_hi)
            st_d.eb = wl[EB_HI_LSB +: EB_W];
        else if (ld_lo)
            st_d.eb = wl[EB_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ebank = st_q.eb;

    AST_EB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hi || ld_lo) |=> $stable(ebank)); // R5
    AST_EB_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !ld_hi) |=> ebank == $past(wl[EB_W-1:0])); // R5
    AST_EB_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> ebank == $past(wl[EB_HI_LSB +: EB_W])); // R5

endmodule

// File: rtl/chdec_chan.sv
module chdec_chan #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned CH_AW   = 6,
    parameter int unsigned SB_W    = 3,
    parameter int unsigned SB_LSB  = 4,
    parameter int unsigned SB_CH   = 7,
    parameter int unsigned TEST_CH = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_AW-1:0]  ch_addr,
    input  logic              ch_rd,
    input  logic              ch_wr,
    input  logic [WORD_W-1:0] wl,
    output logic [WORD_W-1:0] wl_out,
    output logic [SB_W-1:0]   sbank
);
    localparam int unsigned CH_W = WORD_W - 1;

    typedef struct packed {
        logic [SB_W-1:0] sb;
        logic [CH_W-1:0] tst;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit_sb, hit_tst;
    logic [WORD_W-1:0] ch_or;

    assign hit_sb  = (ch_addr == CH_AW'(SB_CH));
    assign hit_tst = (ch_addr == CH_AW'(TEST_CH));

    always_comb begin
        st_d = st_q;
        if (ch_wr && hit_sb)
            st_d.sb = wl[SB_LSB +: SB_W];
        if (ch_wr && hit_tst)
            st_d.tst = {wl[WORD_W-1], wl[WORD_W-3:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // channel-OR bus: every implemented channel ORs its word when addressed
    always_comb begin
        ch_or = '0;
        if (hit_sb)
            ch_or[SB_LSB +: SB_W] = st_q.sb;
        if (hit_tst)
            ch_or = ch_or | {st_q.tst[CH_W-1], 1'b0, st_q.tst[CH_W-2:0]};
    end

    assign wl_out = ch_rd ? ch_or : '0;
    assign sbank  = st_q.sb;

    AST_SB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_wr && hit_sb) |=> $stable(sbank)); // R6
    AST_SB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr && hit_sb) |=> sbank == $past(wl[SB_LSB +: SB_W])); // R6

endmodule

// File: rtl/chan_addr_decoder.sv
module chan_addr_decoder
    import chdec_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned EB_W      = 3,
    parameter int unsigned EB_HI_LSB = 8,
    parameter int unsigned SB_W      = 3,
    parameter int unsigned SB_LSB    = 4,
    parameter int unsigned SB_CH     = 7,
    parameter int unsigned TEST_CH   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              sc_rd,
    input  logic              sc_wr,
    input  logic              ch_rd,
    input  logic              ch_wr,
    input  logic [WORD_W-1:0] wl_in,
    output logic              sc_qual,
    output logic [7:0]        lo_dec,
    output logic [7:0]        mid_dec,
    output logic [7:0]        reg_rd,
    output logic [7:0]        reg_wr,
    output logic [WORD_W-1:0] wl_out,
    output logic [EB_W-1:0]   ebank,
    output logic [SB_W-1:0]   sbank
);
    localparam int unsigned SEL_W = 3;
    localparam int unsigned CH_AW = 2 * SEL_W;

    chdec_addr #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_addr (
        .s_addr  (s_addr),
        .sc_rd   (sc_rd),
        .sc_wr   (sc_wr),
        .ch_rd   (ch_rd),
        .ch_wr   (ch_wr),
        .sc_qual (sc_qual),
        .lo_dec  (lo_dec),
        .mid_dec (mid_dec),
        .reg_rd  (reg_rd),
        .reg_wr  (reg_wr)
    );

    chdec_ebank #(
        .WORD_W    (WORD_W),
        .EB_W      (EB_W),
        .EB_HI_LSB (EB_HI_LSB)
    ) u_ebank (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (reg_wr[REG_EBK]),
        .ld_lo (reg_wr[REG_BOTH]),
        .wl    (wl_in),
        .ebank (ebank)
    );

    chdec_chan #(
        .WORD_W  (WORD_W),
        .CH_AW   (CH_AW),
        .SB_W    (SB_W),
        .SB_LSB  (SB_LSB),
        .SB_CH   (SB_CH),
        .TEST_CH (TEST_CH)
    ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_addr (s_addr[CH_AW-1:0]),
        .ch_rd   (ch_rd),
        .ch_wr   (ch_wr),
        .wl      (wl_in),
        .wl_out  (wl_out),
        .sbank   (sbank)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rd) && $onehot0(reg_wr)); // R3
    AST_QL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd[REG_LOWP] || reg_rd[REG_RET]) |-> wl_out == '0); // R8
    AST_CH_Q_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rd && s_addr[CH_AW-1:0] == CH_AW'(2)) |-> reg_rd[REG_RET]); // R4
    AST_CH_L_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr && s_addr[CH_AW-1:0] == CH_AW'(1)) |-> reg_wr[REG_LOWP]); // R4

endmodule

// File: tb/chan_addr_decoder_bench.sv
`timescale 1ns/1ps
module chan_addr_decoder_bench;

    localparam logic [3:0] P_NONE = 4'b0000;
    localparam logic [3:0] P_SCR  = 4'b0001;
    localparam logic [3:0] P_SCW  = 4'b0010;
    localparam logic [3:0] P_CHR  = 4'b0100;
    localparam logic [3:0] P_CHW  = 4'b1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] s_addr = '0;
    logic        sc_rd = 1'b0, sc_wr = 1'b0, ch_rd = 1'b0, ch_wr = 1'b0;
    logic [15:0] wl_in = '0;
    logic        sc_qual;
    logic [7:0]  lo_dec, mid_dec, reg_rd, reg_wr;
    logic [15:0] wl_out;
    logic [2:0]  ebank, sbank;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string cur_req = "R10";

    // reference state
    logic [2:0]  m_eb = '0;
    logic [2:0]  m_sb = '0;
    logic [14:0] m_tst = '0;

    always #2.5 clk = ~clk;

    chan_addr_decoder u_chan_addr_decoder (
        .clk(clk), .rst_n(rst_n), .s_addr(s_addr),
        .sc_rd(sc_rd), .sc_wr(sc_wr), .ch_rd(ch_rd), .ch_wr(ch_wr),
        .wl_in(wl_in), .sc_qual(sc_qual), .lo_dec(lo_dec), .mid_dec(mid_dec),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .wl_out(wl_out),
        .ebank(ebank), .sbank(sbank)
    );

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic        e_q;
        logic [7:0]  e_lo, e_mid, e_rd, e_wr;
        logic [15:0] e_wl;
        logic [5:0]  c;
        c     = s_addr[5:0];
        e_q   = (s_addr[11:3] == 9'd0);                 // R1
        e_lo  = 8'd1 << s_addr[2:0];                    // R2
        e_mid = 8'd1 << s_addr[5:3];                    // R2
        e_rd  = '0;
        e_wr  = '0;
        for (int k = 0; k < 8; k++) begin              // R3 R4
            if (sc_rd && e_q && s_addr[2:0] == k) e_rd[k] = 1'b1;
            if (sc_wr && e_q && s_addr[2:0] == k) e_wr[k] = 1'b1;
            if ((k == 1 || k == 2) && c == k) begin
                if (ch_rd) e_rd[k] = 1'b1;
                if (ch_wr) e_wr[k] = 1'b1;
            end
        end
        e_wl = '0;                                      // R8
        if (ch_rd && c == 6'd7)  e_wl[6:4] = m_sb;      // R6
        if (ch_rd && c == 6'd11) e_wl = {m_tst[14], 1'b0, m_tst[13:0]}; // R7
        chk("R1 sc_qual", {15'd0, sc_qual}, {15'd0, e_q});
        chk("R2 lo_dec", {8'd0, lo_dec}, {8'd0, e_lo});
        chk("R2 mid_dec", {8'd0, mid_dec}, {8'd0, e_mid});
        chk("R3 R4 R9 reg_rd", {8'd0, reg_rd}, {8'd0, e_rd});
        chk("R3 R4 R9 reg_wr", {8'd0, reg_wr}, {8'd0, e_wr});
        chk("R8 wl_out", wl_out, e_wl);
        chk("R5 ebank", {13'd0, ebank}, {13'd0, m_eb});
        chk("R6 sbank", {13'd0, sbank}, {13'd0, m_sb});
    endtask

    task automatic update_model();
        if (sc_wr && s_addr[11:3] == 9'd0) begin
            if (s_addr[2:0] == 3'd3) m_eb = wl_in[10:8];
            if (s_addr[2:0] == 3'd6) m_eb = wl_in[2:0];
        end
        if (ch_wr && s_addr[5:0] == 6'd7)  m_sb  = wl_in[6:4];
        if (ch_wr && s_addr[5:0] == 6'd11) m_tst = {wl_in[15], wl_in[13:0]};
    endtask

    task automatic step(logic [11:0] a, logic [3:0] p, logic [15:0] d);
        @(negedge clk);
        s_addr = a;
        {ch_wr, ch_rd, sc_wr, sc_rd} = p;
        wl_in = d;
        #1;
        compare_all();
        @(posedge clk);
        update_model();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("[TB] FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: state zero after reset, test channel reads zero
        cur_req = "R10";
        step(12'o0013, P_CHR, 16'h0000);
        step(12'o0007, P_CHR, 16'h0000);

        // R1 R2 R3: special reads and writes across all eight registers
        cur_req = "R3";
        for (int i = 0; i < 8; i++) step(12'(i), P_SCR, 16'h0000);
        for (int i = 0; i < 8; i++) step(12'(i), P_SCW, 16'h0000);
        // R1: any upper bit set blocks the special strobes
        cur_req = "R1";
        step(12'o0010, P_SCR, 16'h0);
        step(12'o4002, P_SCW, 16'h0);
        step(12'o1003, P_SCW, 16'h0700);   // no bank load expected
        step(12'o0100, P_SCR, 16'h0);

        // R4: Q and L aliases with varied upper bits, bit 9 included
        cur_req = "R4";
        step(12'o0002, P_CHR, 16'h0);
        step(12'o1002, P_CHW, 16'hFFFF);
        step(12'o7702, P_CHR, 16'h0);
        step(12'o0101, P_CHW, 16'h1234);
        step(12'o1001, P_CHR, 16'h0);
        step(12'o0003, P_CHW, 16'h0);       // channel 3: no strobe
        step(12'o0012, P_CHR, 16'h0);       // not Q: mid bits differ

        // R5: bank register from two fields
        cur_req = "R5";
        step(12'o0003, P_SCW, 16'h0500);
        step(12'o0000, P_NONE, 16'h0);
        step(12'o0006, P_SCW, 16'hFFFA);
        step(12'o0000, P_NONE, 16'h0);
        step(12'o0005, P_SCW, 16'hFFFF);    // other register, no change
        step(12'o0003, P_CHW, 16'hFFFF);    // channel write, no change
        step(12'o0000, P_NONE, 16'h0);

        // R6: superbank flip-flops through channel 7 only
        cur_req = "R6";
        step(12'o1007, P_CHW, 16'h0050);
        step(12'o0007, P_CHR, 16'h0);
        step(12'o0007, P_SCW, 16'hFFFF);    // special write, not a channel
        step(12'o7707, P_CHR, 16'h0);

        // R7: test channel drops write-line bit 14
        cur_req = "R7";
        step(12'o0013, P_CHW, 16'hFFFF);
        step(12'o0013, P_CHR, 16'h0);
        step(12'o2013, P_CHW, 16'h4001);
        step(12'o0113, P_CHR, 16'h0);

        // R8: unimplemented channels and idle bus
        cur_req = "R8";
        step(12'o0015, P_CHR, 16'h0);
        step(12'o0013, P_NONE, 16'h0);
        step(12'o0002, P_CHR, 16'h0);

        // R9: random single-pulse traffic compared every cycle
        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            logic [3:0] p;
            int sel;
            sel = $urandom_range(0, 4);
            p = (sel == 0) ? P_NONE : 4'(1 << (sel - 1));
            step(($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'($urandom_range(0, 15)),
                 p, 16'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule